// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block sits between a 2-bit, 50 MHz reduced-pin Ethernet receive interface and one byte-wide receive buffer. While the receive-valid input is high it drops preamble symbols until the start-of-frame symbol `2'b11` arrives. After that it packs every four symbols into a byte and writes each byte into the buffer that is currently assigned. The frame data starts at offset 2. The two bytes in front of it are reserved for a length header, which is filled in once the frame has ended.

A frame is taken as finished only when receive-valid has stayed low for several consecutive cycles. A short drop inside the frame does not end it. When the frame ends, the block writes a fixed marker byte just after the data. It then writes the two length bytes with an idle cycle between them. After a fixed delay it pulses a completion output to the buffer ring manager. At that same moment it updates two destination flags, one for broadcast and one for multicast. CRC checking and buffer allocation belong to other blocks. The header is written for every frame, whatever its content.

Top module: `rx_frame_writer`

## Requirements
- R1: While in idle, every symbol other than `2'b11` is discarded, and so is any cycle with valid low. No buffer write and no completion pulse result from a preamble that is not followed by `2'b11`.
- R2: After the start symbol, each four valid symbols form one byte. The first symbol goes into bits 1:0 and the fourth into bits 7:6. Frame byte k is written at offset 2+k. With valid held high, successive frame-byte writes are exactly 4 cycles apart.
- R3: The frame ends only after valid has been sampled low on 3 consecutive cycles. A drop of 1 or 2 cycles is bridged, and no symbol is taken during it. The marker write appears 3 cycles after the first low sample is driven.
- R4: The marker byte 0xEA is written at offset 2+N, where N is the number of stored frame bytes. An incomplete last byte is discarded. The marker is the write immediately before the length low byte.
- R5: The length is little-endian: N[7:0] goes to offset 0 and N[15:8] to offset 1. The low byte is written in the cycle after the marker. The next cycle has no write, and the high byte follows 2 cycles after the low byte.
- R6: `frame_done` is a pulse one cycle wide. It appears exactly 15 cycles after the length high byte write, once per frame.
- R7: When the frame holds at least 6 bytes and the first six are all 0xFF, `dest_bcast` is set and `dest_mcast` is cleared. The flags are updated with `frame_done` and held until the next one.
- R8: `dest_mcast` is set when the frame holds at least 6 bytes, bit 0 of the first byte is 1, and the frame is not broadcast. Frames shorter than 6 bytes clear both flags.
- R9: A buffer of 2^ADDR_W bytes holds at most 2^ADDR_W-3 frame bytes. Bytes beyond that are not written and N stops at that limit, so a full frame makes exactly N+3 writes.
- R10: Right after reset, no write and no completion pulse are asserted, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive data valid |
| rx_sym | input | 2 | Receive symbol |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | ADDR_W | Buffer byte offset |
| buf_data | output | 8 | Buffer write data |
| frame_done | output | 1 | Frame completion pulse to the ring manager |
| dest_bcast | output | 1 | Last frame had a broadcast destination |
| dest_mcast | output | 1 | Last frame had a multicast destination |

## Verification
Each result has a fixed cycle of arrival, and the bench measures against it. A data byte is written on the edge that samples its fourth symbol. The marker appears three cycles after valid is first driven low. The length low byte follows one cycle after the marker and the high byte two cycles after that. The completion pulse and the flags arrive fifteen cycles after the high byte. A cycle counter runs in the bench, and a monitor on the falling edge stamps every write and pulse with it. Each frame is compared against these offsets and against contents and a length computed from the bytes the bench itself drove.

// File: rtl/rxbw_pkg.sv
package rxbw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DATA,
    S_LEN_LO,
    S_GAP,
    S_LEN_HI,
    S_WAIT
  } wr_state_t;

  localparam logic [1:0] SYM_START = 2'b11;

  // select one byte of a 16-bit little-endian length
  function automatic logic [7:0] fn_len_byte(input logic [15:0] len, input logic hi);
    return hi ? len[15:8] : len[7:0];
  endfunction

  function automatic logic fn_is_bcast(input logic seen6, input logic all_ones);
    return seen6 & all_ones;
  endfunction

  function automatic logic fn_is_mcast(input logic seen6, input logic all_ones, input logic grp);
    return seen6 & grp & ~all_ones;
  endfunction

endpackage

// File: rtl/rxbw_sym_asm.sv
module rxbw_sym_asm #(
  parameter int SYM_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int SPB  = BYTE_W / SYM_W;
  localparam int CW   = $clog2(SPB);
  localparam int SH_W = BYTE_W - SYM_W;

  logic [CW-1:0]   dcnt;
  logic [SH_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      dcnt  <= '0;
      shreg <= '0;
    end else if (sym_valid) begin
      dcnt  <= dcnt + 1'b1;
      shreg <= {sym, shreg[SH_W-1:SYM_W]};
    end
  end

  assign byte_stb = active && sym_valid && (dcnt == CW'(SPB - 1));
  assign byte_val = {sym, shreg};

  assert_byte_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);

endmodule

// File: rtl/rxbw_end_det.sv
module rxbw_end_det #(
  parameter int END_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rx_valid,
  output logic end_stb
);
  localparam int LC_W = $clog2(END_LOW + 1);

  logic [LC_W-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || rx_valid) lowcnt <= '0;
    else                               lowcnt <= lowcnt + 1'b1;
  end

  assign end_stb = active && !rx_valid && (lowcnt == LC_W'(END_LOW - 1));

  generate
    if (END_LOW >= 3) begin : g_chk3
      assert_end_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |-> (!rx_valid && !$past(rx_valid) && !$past(rx_valid, 2)));
    end else begin : g_chk1
      assert_end_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |-> !rx_valid);
    end
  endgenerate

endmodule

// File: rtl/rxbw_dest_cls.sv
module rxbw_dest_cls (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  output logic       seen6,
  output logic       all_ones,
  output logic       grp
);
  localparam int DST_BYTES = 6;

  logic [2:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx      <= '0;
      all_ones <= 1'b1;
      grp      <= 1'b0;
    end else if (byte_stb && idx < 3'(DST_BYTES)) begin
      idx      <= idx + 1'b1;
      all_ones <= all_ones & (&byte_val);
      if (idx == 3'd0) grp <= byte_val[0];
    end
  end

  assign seen6 = (idx == 3'(DST_BYTES));

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
  import rxbw_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         END_LOW    = 3,
  parameter int         DONE_DELAY = 15,
  parameter logic [7:0] MARKER     = 8'hEA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [1:0]        rx_sym,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              frame_done,
  output logic              dest_bcast,
  output logic              dest_mcast
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int HDR      = 2;
  localparam int MAX_DATA = DEPTH - HDR - 1;
  localparam int DLY_W    = $clog2(DONE_DELAY + 1);

  wr_state_t         state;
  logic [ADDR_W-1:0] nbytes;
  logic [DLY_W-1:0]  dly;

  // named internal events
  logic       active;
  logic       byte_stb;
  logic [7:0] byte_val;
  logic       end_stb;
  logic       seen6, all_ones, grp;
  logic       room;

  assign active = (state == S_DATA);
  assign room   = (nbytes < ADDR_W'(MAX_DATA));

  rxbw_sym_asm #(.SYM_W(2), .BYTE_W(8)) u_asm (
    .clk(clk), .rst_n(rst_n), .active(active), .sym_valid(rx_valid),
    .sym(rx_sym), .byte_stb(byte_stb), .byte_val(byte_val)
  );

  rxbw_end_det #(.END_LOW(END_LOW)) u_end (
    .clk(clk), .rst_n(rst_n), .active(active), .rx_valid(rx_valid),
    .end_stb(end_stb)
  );

  rxbw_dest_cls u_cls (
    .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE), .byte_stb(byte_stb),
    .byte_val(byte_val), .seen6(seen6), .all_ones(all_ones), .grp(grp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      nbytes     <= '0;
      dly        <= '0;
      buf_we     <= 1'b0;
      buf_addr   <= '0;
      buf_data   <= '0;
      frame_done <= 1'b0;
      dest_bcast <= 1'b0;
      dest_mcast <= 1'b0;
    end else begin
      buf_we     <= 1'b0;
      frame_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          nbytes <= '0;
          if (rx_valid && rx_sym == SYM_START) state <= S_DATA;
        end
        S_DATA: begin
          if (end_stb) begin
            buf_we   <= 1'b1;
            buf_addr <= ADDR_W'(HDR) + nbytes;
            buf_data <= MARKER;
            state    <= S_LEN_LO;
          end else if (byte_stb && room) begin
            buf_we   <= 1'b1;
            buf_addr <= ADDR_W'(HDR) + nbytes;
            buf_data <= byte_val;
            nbytes   <= nbytes + 1'b1;
          end
        end
        S_LEN_LO: begin
          buf_we   <= 1'b1;
          buf_addr <= '0;
          buf_data <= fn_len_byte(16'(nbytes), 1'b0);
          state    <= S_GAP;
        end
        S_GAP: state <= S_LEN_HI;
        S_LEN_HI: begin
          buf_we   <= 1'b1;
          buf_addr <= ADDR_W'(1);
          buf_data <= fn_len_byte(16'(nbytes), 1'b1);
          dly      <= DLY_W'(1);
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (dly == DLY_W'(DONE_DELAY)) begin
            frame_done <= 1'b1;
            dest_bcast <= fn_is_bcast(seen6, all_ones);
            dest_mcast <= fn_is_mcast(seen6, all_ones, grp);
            state      <= S_IDLE;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_marker_before_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && buf_addr == '0) |-> ($past(buf_we) && $past(buf_data) == MARKER));

  assert_gap_after_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && buf_addr == '0) |=> !buf_we);

  assert_hi_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && buf_addr == ADDR_W'(1)) |-> (!$past(buf_we) && $past(buf_we, 2) && $past(buf_addr, 2) == '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dest_bcast && dest_mcast));

  assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !buf_we);

endmodule

// File: tb/rx_frame_writer_test.sv
module rx_frame_writer_test;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int MAXD = DEPTH - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic buf_we;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic frame_done, dest_bcast, dest_mcast;

  rx_frame_writer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sym(rx_sym),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_done(frame_done), .dest_bcast(dest_bcast), .dest_mcast(dest_mcast)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] bmem [0:DEPTH-1];
  logic [7:0] fb [0:599];
  int nwr, ndone, t_lo, t_hi, t_mk, t_prev, t_done, t_b0, t_b1, t_vlow;

  always @(negedge clk) begin
    if (buf_we) begin
      bmem[buf_addr] = buf_data;
      nwr++;
      if (buf_addr == 0) begin t_lo = cyc; t_mk = t_prev; end
      if (buf_addr == 1) t_hi = cyc;
      if (buf_addr == 2) t_b0 = cyc;
      if (buf_addr == 3) t_b1 = cyc;
      t_prev = cyc;
    end
    if (frame_done) begin ndone++; t_done = cyc; end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int n, input int seed, input int mode);
    for (int k = 0; k < 600; k++) fb[k] = 8'((k * 37 + seed * 11 + 3) & 255);
    if (mode == 1) for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
    if (mode == 2) begin
      fb[0] = 8'h01; fb[1] = 8'h00; fb[2] = 8'h5E; fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = 8'hFB;
    end
    if (mode == 3) fb[0] = 8'h02;
    if (mode == 4) begin
      for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
      fb[3] = 8'hFE;
    end
    if (n < 0) fb[0] = fb[0];
  endtask

  task automatic clear_mon;
    for (int a = 0; a < DEPTH; a++) bmem[a] = 8'h5A;
    nwr = 0; ndone = 0; t_lo = -1; t_hi = -1; t_mk = -1; t_done = -1; t_b0 = -1; t_b1 = -1;
  endtask

  // preamble with odd symbols, start symbol, then bytes LS pair first
  task automatic drive(input int n, input int gap_len, input int gap_pos);
    @(negedge clk); rx_valid = 1'b1; rx_sym = 2'b00;
    @(negedge clk); rx_sym = 2'b10;
    for (int p = 0; p < 6; p++) begin @(negedge clk); rx_sym = 2'b01; end
    @(negedge clk); rx_sym = 2'b11;
    for (int k = 0; k < n; k++) begin
      for (int d = 0; d < 4; d++) begin
        if (k == gap_pos && d == 1) begin
          for (int g = 0; g < gap_len; g++) begin
            @(negedge clk); rx_valid = 1'b0; rx_sym = 2'b11;
          end
        end
        @(negedge clk); rx_valid = 1'b1; rx_sym = fb[k][2*d +: 2];
      end
    end
    @(negedge clk); rx_valid = 1'b0; rx_sym = 2'b00; t_vlow = cyc;
    for (int w = 0; w < 30; w++) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int seed, input int mode, input int gap_len, input int gap_pos);
    int nexp, bad;
    bit bc, mc;
    fill(n, seed, mode);
    clear_mon();
    drive(n, gap_len, gap_pos);
    nexp = (n > MAXD) ? MAXD : n;
    bad = 0;
    for (int k = 0; k < nexp; k++) if (bmem[2 + k] !== fb[k]) bad++;
    chk(bad == 0, "R2 frame bytes mismatches", bad, 0);
    chk(bmem[2 + nexp] == 8'hEA, "R4 marker value", int'(bmem[2 + nexp]), 'hEA);
    chk(t_lo == t_mk + 1, "R4 marker just before length low", t_lo - t_mk, 1);
    chk(t_mk == t_vlow + 3, "R3 end after three low cycles", t_mk - t_vlow, 3);
    chk(bmem[0] == 8'(nexp & 255), "R5 length low byte", int'(bmem[0]), nexp & 255);
    chk(bmem[1] == 8'(nexp >> 8), "R5 length high byte", int'(bmem[1]), nexp >> 8);
    chk(t_hi == t_lo + 2, "R5 spaced length writes", t_hi - t_lo, 2);
    chk(nwr == nexp + 3, "R9 write count", nwr, nexp + 3);
    chk(ndone == 1, "R6 one done pulse", ndone, 1);
    chk(t_done == t_hi + 15, "R6 done delay", t_done - t_hi, 15);
    bc = (nexp >= 6) && (fb[0] == 8'hFF) && (fb[1] == 8'hFF) && (fb[2] == 8'hFF)
         && (fb[3] == 8'hFF) && (fb[4] == 8'hFF) && (fb[5] == 8'hFF);
    mc = (nexp >= 6) && fb[0][0] && !bc;
    chk(dest_bcast == bc, "R7 broadcast flag", int'(dest_bcast), int'(bc));
    chk(dest_mcast == mc, "R8 multicast flag", int'(dest_mcast), int'(mc));
    if (n >= 2 && gap_len == 0)
      chk(t_b1 == t_b0 + 4, "R2 byte spacing", t_b1 - t_b0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(buf_we == 1'b0, "R10 no write in reset", int'(buf_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buf_we == 1'b0 && frame_done == 1'b0, "R10 quiet after reset", int'(buf_we) + int'(frame_done), 0);
    chk(dest_bcast == 1'b0 && dest_mcast == 1'b0, "R10 flags clear", int'(dest_bcast) + int'(dest_mcast), 0);

    for (int n = 0; n <= 20; n++) run_frame(n, n, 0, 0, -1);
    run_frame(64, 1, 1, 0, -1);
    run_frame(64, 2, 2, 0, -1);
    run_frame(64, 3, 3, 0, -1);
    run_frame(64, 4, 4, 0, -1);
    run_frame(5, 5, 1, 0, -1);
    run_frame(6, 6, 1, 0, -1);
    run_frame(300, 7, 0, 0, -1);
    run_frame(10, 8, 2, 1, 3);
    run_frame(10, 9, 1, 2, 5);
    run_frame(12, 10, 0, 2, 0);
    run_frame(515, 11, 1, 0, -1);

    // R1: preamble without a start symbol leaves buffer and flags untouched
    clear_mon();
    for (int p = 0; p < 40; p++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sym = (p % 3 == 0) ? 2'b10 : 2'b01;
    end
    @(negedge clk); rx_valid = 1'b0; rx_sym = 2'b00;
    for (int w = 0; w < 30; w++) @(negedge clk);
    chk(nwr == 0, "R1 no writes without start symbol", nwr, 0);
    chk(ndone == 0, "R1 no done without start symbol", ndone, 0);
    chk(dest_bcast == 1'b1, "R1 flags held", int'(dest_bcast), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule